// File: doc/BRIEF.md
# Serial Avionics Word Transmitter with Inter-Word Null

This block turns parallel data words, taken one at a time from the head of a transmit queue, into a return-to-zero bipolar serial stream. For each word it appends a parity bit of the selected sense and sends the bits least significant first. Each bit time starts with a half-bit pulse on the positive or the negative drive line, followed by a half-bit null. After every word it holds both drive lines low for four bit times, then starts the next queued word straight away. Two word formats are supported: 31 data bits plus parity, or 24 data bits plus parity. The bit time is either 10 or 80 system clocks.

The queue head is presented on a valid/ready pair. The block raises `word_ready` only while `tx_enable` is high and the serializer is at a word boundary: either idle, or in the last cycle of a null gap. A word is taken in a cycle where both `word_valid` and `word_ready` are high. The queue may hold `word_valid` high for as long as it likes, and the block takes no word until it is free. `word_data` only needs to be valid in the accepting cycle, because the block keeps its own copy. Clearing `tx_enable` aborts the word in progress and discards it. A combinational empty flag reports that the serializer is idle and no word is waiting. The positive and negative drive signals go to an external line driver. A loopback output carries the plain bit value so that a local receiver can be fed during self test. A bit-rate clock output is also provided.

Top module: `a429_tx_serializer`

## Requirements
- R1: A word is sent starting with `word_data[0]`. During the first half of each bit time (cycles 0..DIV/2-1 of the bit), `line_pos` is high for a 1 and `line_neg` is high for a 0. Both lines are low during the second half of the bit time, and the two lines are never high together.
- R2: The parity bit is sent right after the last data bit. With `cfg_even_parity`=0, the data bits plus parity contain an odd number of ones. With `cfg_even_parity`=1, they contain an even number.
- R3: With `cfg_short_word`=0, a word is `word_data[30:0]` followed by parity, 32 bit times in all. With `cfg_short_word`=1, a word is `word_data[23:0]` followed by parity, 25 bit times in all, and `word_data[30:24]` has no effect on the stream.
- R4: One bit time is 10 clocks when `cfg_slow_rate`=0 and 80 clocks when it is 1. `bit_clk` is high in the first half and low in the second half of every bit time while a word or its gap is in progress, and is low when idle.
- R5: Every word is followed by 4 bit times with both drive lines low. The next word, if one is valid, begins in the cycle right after that gap. A back-to-back frame therefore lasts 36 or 29 bit times, and eight words last 288 or 232 bit times up to the return to idle.
- R6: `word_ready` is high only when `tx_enable` is high and the block is idle or in the final cycle of a gap. It stays low while a word is being sent and whenever `tx_enable` is low, whatever `word_valid` does.
- R7: When `tx_enable` is sampled low during a word or a gap, the block returns to idle at that clock edge. All outputs are low from then on, the rest of the word is dropped, and the next transmission begins with the next queued word.
- R8: `tx_empty` is high exactly when the block is idle and `word_valid` is low.
- R9: `loop_data` equals the value of the bit being sent for the whole bit time, and is low during gaps and while idle.
- R10: Word length, parity sense and rate are sampled in the cycle a word is accepted. Changing them while that word is being sent has no effect on it.
- R11: During and right after reset, all serial outputs and `word_ready` are low while `tx_enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_short_word | input | 1 | 1 selects 24 data bits, 0 selects 31 |
| cfg_even_parity | input | 1 | 1 selects even parity, 0 odd |
| cfg_slow_rate | input | 1 | 1 selects 80 clocks per bit, 0 selects 10 |
| tx_enable | input | 1 | Transmission enable; clearing it aborts the word in progress |
| word_valid | input | 1 | Queue head holds a word |
| word_data | input | 31 | Queue head word, bit 0 sent first |
| word_ready | output | 1 | Block takes the head word in this cycle if valid |
| line_pos | output | 1 | Positive-side drive pulse |
| line_neg | output | 1 | Negative-side drive pulse |
| bit_clk | output | 1 | Bit-rate clock, high in first half of each bit time |
| loop_data | output | 1 | Current bit value for loopback |
| tx_empty | output | 1 | Idle with no word waiting |

## Verification
A sequencer stuck in the wrong state, or a bit counter off by one, shows up at the ports within one frame. It appears as a missing or extra bit time, a parity pulse on the wrong line, or a gap that is shorter than four bit times, and each of these moves the next word's first pulse away from its expected cycle. A bit-timer fault breaks the half-bit pulse widths on `bit_clk` and the drive lines within a single bit time. Configuration that is latched wrongly corrupts only the words accepted after the change, and this is visible as soon as their first bits are sent. The bench compares every clock cycle of every word and gap against a model built from the requirements. It also compares the cycle distance between word starts against the frame lengths.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_e;

endpackage

// File: rtl/a429_bit_timer.sv
module a429_bit_timer #(
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic bit_end,
  output logic first_half
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW      = $clog2(DIV_MAX);
  localparam logic [CW-1:0] FAST_LAST = CW'(DIV_FAST - 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(DIV_SLOW - 1);
  localparam logic [CW-1:0] FAST_HALF = CW'(DIV_FAST / 2);
  localparam logic [CW-1:0] SLOW_HALF = CW'(DIV_SLOW / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_v;
  logic [CW-1:0] half_v;

  always_comb begin
    last_v = slow ? SLOW_LAST : FAST_LAST;
    half_v = slow ? SLOW_HALF : FAST_HALF;
  end

  assign bit_end    = run && (cnt_q == last_v);
  assign first_half = run && (cnt_q < half_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run)         cnt_q <= '0;
    else if (cnt_q == last_v) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_v); // R4

  AST_IDLE_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/a429_tx_sequencer.sv
module a429_tx_sequencer
  import a429_tx_pkg::*;
#(
  parameter int LONG_W   = 31,
  parameter int SHORT_W  = 24,
  parameter int GAP_BITS = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_enable,
  input  logic      word_valid,
  input  logic      cfg_short,
  input  logic      cfg_slow,
  input  logic      bit_end,
  output tx_state_e state,
  output logic      slow_q,
  output logic      word_ready,
  output logic      load,
  output logic      shift,
  output logic      tx_empty
);
  localparam int SPAN  = (LONG_W + 1 > GAP_BITS) ? LONG_W + 1 : GAP_BITS;
  localparam int CNT_W = $clog2(SPAN);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_W);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W);
  localparam logic [CNT_W-1:0] LAST_GAP   = CNT_W'(GAP_BITS - 1);

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             short_q;
  logic             gap_done;
  logic             last_data;

  assign state     = state_q;
  assign gap_done  = (state_q == ST_GAP) && bit_end && (cnt_q == LAST_GAP);
  assign last_data = (cnt_q == (short_q ? LAST_SHORT : LAST_LONG));
  assign word_ready = tx_enable && ((state_q == ST_IDLE) || gap_done);
  assign load      = word_ready && word_valid;
  assign shift     = (state_q == ST_DATA) && bit_end;
  assign tx_empty  = (state_q == ST_IDLE) && !word_valid;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (load) begin
          state_d = ST_DATA;
          cnt_d   = '0;
        end
      end
      ST_DATA: begin
        if (!tx_enable) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (bit_end) begin
          if (last_data) begin
            state_d = ST_GAP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (!tx_enable) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (bit_end) begin
          if (cnt_q == LAST_GAP) begin
            state_d = load ? ST_DATA : ST_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      short_q <= 1'b0;
      slow_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (load) begin
        short_q <= cfg_short;
        slow_q  <= cfg_slow;
      end
    end
  end

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !tx_enable) |=> (state_q == ST_IDLE)); // R7

  AST_LOAD_STARTS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state_q == ST_DATA) && (cnt_q == '0)); // R6

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && !load) |=> $stable(short_q) && $stable(slow_q)); // R10

  AST_GAP_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_GAP) |-> ($past(state_q) == ST_DATA)); // R5
endmodule

// File: rtl/a429_word_shifter.sv
module a429_word_shifter #(
  parameter int LONG_W  = 31,
  parameter int SHORT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              short_sel,
  input  logic              even_sel,
  input  logic [LONG_W-1:0] word,
  output logic              cur_bit
);
  localparam int FRAME_W = LONG_W + 1;

  logic [LONG_W-1:0]  short_mask;
  logic [LONG_W-1:0]  short_data;
  logic               par_long;
  logic               par_short;
  logic [FRAME_W-1:0] frame_long;
  logic [FRAME_W-1:0] frame_short;
  logic [FRAME_W-1:0] sh_q;

  for (genvar i = 0; i < LONG_W; i++) begin : g_mask
    assign short_mask[i] = (i < SHORT_W);
  end

  assign short_data = word & short_mask;
  // odd sense: parity bit makes the total count of ones odd
  assign par_long   = even_sel ? (^word)       : ~(^word);
  assign par_short  = even_sel ? (^short_data) : ~(^short_data);

  assign frame_long  = {par_long, word};
  assign frame_short = {1'b0, short_data} | (FRAME_W'(par_short) << SHORT_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= short_sel ? frame_short : frame_long;
    else if (shift) sh_q <= {1'b0, sh_q[FRAME_W-1:1]};
  end

  assign cur_bit = sh_q[0];

  AST_FIRST_BIT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_bit == $past(word[0]))); // R1

  AST_SHIFT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (cur_bit == $past(sh_q[1]))); // R1
endmodule

// File: rtl/a429_line_encoder.sv
module a429_line_encoder (
  input  logic clk,
  input  logic rst_n,
  input  logic sending,
  input  logic first_half,
  input  logic cur_bit,
  output logic line_pos,
  output logic line_neg,
  output logic bit_clk,
  output logic loop_data
);
  assign line_pos  = sending && first_half && cur_bit;
  assign line_neg  = sending && first_half && !cur_bit;
  assign bit_clk   = first_half;
  assign loop_data = sending && cur_bit;

  AST_LINES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_pos && line_neg)); // R1

  AST_LOOP_MATCHES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    line_pos |-> loop_data); // R9
endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer
  import a429_tx_pkg::*;
#(
  parameter int LONG_W   = 31,
  parameter int SHORT_W  = 24,
  parameter int GAP_BITS = 4,
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_short_word,
  input  logic              cfg_even_parity,
  input  logic              cfg_slow_rate,
  input  logic              tx_enable,
  input  logic              word_valid,
  input  logic [LONG_W-1:0] word_data,
  output logic              word_ready,
  output logic              line_pos,
  output logic              line_neg,
  output logic              bit_clk,
  output logic              loop_data,
  output logic              tx_empty
);
  tx_state_e state;
  logic      slow_q;
  logic      load;
  logic      shift;
  logic      bit_end;
  logic      first_half;
  logic      cur_bit;

  a429_tx_sequencer #(
    .LONG_W(LONG_W), .SHORT_W(SHORT_W), .GAP_BITS(GAP_BITS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_enable  (tx_enable),
    .word_valid (word_valid),
    .cfg_short  (cfg_short_word),
    .cfg_slow   (cfg_slow_rate),
    .bit_end    (bit_end),
    .state      (state),
    .slow_q     (slow_q),
    .word_ready (word_ready),
    .load       (load),
    .shift      (shift),
    .tx_empty   (tx_empty)
  );

  a429_bit_timer #(
    .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (state != ST_IDLE),
    .slow       (slow_q),
    .bit_end    (bit_end),
    .first_half (first_half)
  );

  a429_word_shifter #(
    .LONG_W(LONG_W), .SHORT_W(SHORT_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .shift     (shift),
    .short_sel (cfg_short_word),
    .even_sel  (cfg_even_parity),
    .word      (word_data),
    .cur_bit   (cur_bit)
  );

  a429_line_encoder u_enc (
    .clk        (clk),
    .rst_n      (rst_n),
    .sending    (state == ST_DATA),
    .first_half (first_half),
    .cur_bit    (cur_bit),
    .line_pos   (line_pos),
    .line_neg   (line_neg),
    .bit_clk    (bit_clk),
    .loop_data  (loop_data)
  );

  AST_QUIET_OUTSIDE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_DATA) |-> (!line_pos && !line_neg && !loop_data)); // R5

  AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (!bit_clk && !word_ready || tx_enable)); // R8

  AST_NO_READY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |-> !word_ready); // R6
endmodule

// File: tb/test_a429_tx_serializer.sv
module test_a429_tx_serializer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cfg_short_word, cfg_even_parity, cfg_slow_rate, tx_enable;
  logic        word_valid;
  logic [30:0] word_data;
  logic        word_ready, line_pos, line_neg, bit_clk, loop_data, tx_empty;

  a429_tx_serializer i_a429_tx_serializer (
    .clk(clk), .rst_n(rst_n), .cfg_short_word(cfg_short_word),
    .cfg_even_parity(cfg_even_parity), .cfg_slow_rate(cfg_slow_rate),
    .tx_enable(tx_enable), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .line_pos(line_pos), .line_neg(line_neg),
    .bit_clk(bit_clk), .loop_data(loop_data), .tx_empty(tx_empty)
  );

  typedef struct { logic [31:0] bits; int nb; int dv; } exp_t;

  int          n_chk = 0, n_fail = 0, cyc = 0;
  bit          done_flag = 0, mon_on = 1;
  exp_t        exp_q[$];
  logic [30:0] src_q[$];
  int          start_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [30:0] d, input bit sh, input bit ev, input bit sl);
    exp_t e;
    logic [31:0] b;
    int ones;
    e.nb = sh ? 25 : 32;
    e.dv = sl ? 80 : 10;
    b = {1'b0, d};
    if (sh) b = b & 32'h00FF_FFFF;
    ones = $countones(b);
    b[e.nb-1] = ev ? (ones % 2 == 1) : (ones % 2 == 0);
    e.bits = b;
    return e;
  endfunction

  // queue-head source: models the FIFO and records each accepted word as an expected item
  initial begin : source
    bit take;
    word_valid = 1'b0;
    word_data  = '0;
    forever begin
      @(negedge clk);
      take = word_valid && word_ready;
      if (take && mon_on)
        exp_q.push_back(model(word_data, cfg_short_word, cfg_even_parity, cfg_slow_rate));
      @(posedge clk); #1;
      if (take) void'(src_q.pop_front());
      word_valid = (src_q.size() > 0);
      word_data  = (src_q.size() > 0) ? src_q[0] : '0;
    end
  end

  // monitor: on each word start, compares every cycle of the word and its gap
  initial begin : monitor
    exp_t e;
    int   eb_pos, eb_neg, e_loop, e_clk, b, ph, err_bits, err_gap, err_clk, err_loop;
    forever begin
      @(negedge clk);
      if (mon_on && (line_pos || line_neg)) begin
        start_q.push_back(cyc);
        if (exp_q.size() == 0) begin
          check(0, "R6", "word sent without accepted item", 1, 0);
        end else begin
          e = exp_q.pop_front();
          err_bits = 0; err_gap = 0; err_clk = 0; err_loop = 0;
          for (int j = 0; j < (e.nb + 4) * e.dv; j++) begin
            if (j > 0) @(negedge clk);
            b  = j / e.dv;
            ph = j % e.dv;
            e_clk = (ph < e.dv / 2);
            if (b < e.nb) begin
              eb_pos = e_clk && e.bits[b];
              eb_neg = e_clk && !e.bits[b];
              e_loop = e.bits[b];
              if (line_pos !== 1'(eb_pos) || line_neg !== 1'(eb_neg)) err_bits++;
            end else begin
              e_loop = 0;
              if (line_pos !== 1'b0 || line_neg !== 1'b0) err_gap++;
            end
            if (bit_clk !== 1'(e_clk)) err_clk++;
            if (loop_data !== 1'(e_loop)) err_loop++;
          end
          check(err_bits == 0, "R1 R2 R3", "bit/parity cycles wrong", err_bits, 0);
          check(err_gap == 0, "R5", "gap cycles not null", err_gap, 0);
          check(err_clk == 0, "R4", "bit_clk cycles wrong", err_clk, 0);
          check(err_loop == 0, "R9", "loop_data cycles wrong", err_loop, 0);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      check(0, "all", "watchdog expired", cyc, 0);
      finish_run();
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_empty(output int t_end);
    int lim;
    lim = 0;
    do begin
      @(negedge clk);
      lim++;
    end while (!tx_empty && lim < 40000);
    t_end = cyc;
  endtask

  task automatic run_burst(output int t_end);
    step(1);
    tx_enable = 1'b1;
    wait_empty(t_end);
    step(1);
    tx_enable = 1'b0;
  endtask

  task automatic check_frames(input int n, input int nb, input int dv, input int t_end,
                              input string req);
    check(start_q.size() == n, req, "word starts", start_q.size(), n);
    if (start_q.size() == n) begin
      for (int k = 1; k < n; k++)
        check(start_q[k] - start_q[k-1] == (nb + 4) * dv, req, "frame spacing",
              start_q[k] - start_q[k-1], (nb + 4) * dv);
      check(t_end - start_q[0] == n * (nb + 4) * dv, req, "burst length to idle",
            t_end - start_q[0], n * (nb + 4) * dv);
    end
    start_q.delete();
  endtask

  initial begin : main
    int t_end;
    rst_n = 1'b0; cfg_short_word = 1'b0; cfg_even_parity = 1'b0;
    cfg_slow_rate = 1'b0; tx_enable = 1'b0;
    repeat (3) @(negedge clk);
    check(!line_pos && !line_neg && !bit_clk && !loop_data, "R11", "outputs in reset",
          {line_pos, line_neg, bit_clk, loop_data}, 0);
    step(1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!word_ready && !line_pos && !line_neg && !bit_clk, "R11", "outputs after reset",
          {word_ready, line_pos, line_neg, bit_clk}, 0);
    check(tx_empty == 1'b1, "R8", "empty after reset", tx_empty, 1);

    // back-pressure: valid word waits while transmit is off
    src_q.push_back(31'h0000_0000);
    src_q.push_back(31'h7FFF_FFFF);
    src_q.push_back(31'h2AAA_AAAA);
    src_q.push_back(31'h5555_5555);
    src_q.push_back(31'h0000_0001);
    src_q.push_back(31'h4000_0000);
    src_q.push_back(31'h0123_4567);
    src_q.push_back(31'h7EDC_BA98);
    step(20);
    @(negedge clk);
    check(word_valid && !word_ready, "R6", "ready while disabled", word_ready, 0);
    check(!tx_empty, "R8", "empty with word waiting", tx_empty, 0);
    check(!line_pos && !line_neg && !bit_clk, "R6", "line active while disabled",
          {line_pos, line_neg, bit_clk}, 0);

    // eight long odd words at fast rate, ready low mid-word
    fork
      run_burst(t_end);
      begin
        repeat (60) @(negedge clk);
        check(word_valid && !word_ready, "R6", "ready mid-word", word_ready, 0);
      end
    join
    check_frames(8, 32, 10, t_end, "R5");

    // even parity, long words
    cfg_even_parity = 1'b1;
    src_q.push_back(31'h0000_0000);
    src_q.push_back(31'h0135_79BD);
    step(3);
    run_burst(t_end);
    check_frames(2, 32, 10, t_end, "R2");

    // short words, odd parity, upper bits must not matter
    cfg_even_parity = 1'b0;
    cfg_short_word  = 1'b1;
    src_q.push_back(31'h7F00_0000);
    src_q.push_back(31'h7FFF_FFFF);
    src_q.push_back(31'h00AB_CDEF);
    src_q.push_back(31'h5500_0001);
    src_q.push_back(31'h0080_0000);
    src_q.push_back(31'h0000_0000);
    src_q.push_back(31'h2A55_AA55);
    src_q.push_back(31'h0012_3456);
    step(3);
    run_burst(t_end);
    check_frames(8, 25, 10, t_end, "R3");

    // slow rate, long words
    cfg_short_word = 1'b0;
    cfg_slow_rate  = 1'b1;
    src_q.push_back(31'h1357_9ACE);
    src_q.push_back(31'h6000_0003);
    step(3);
    run_burst(t_end);
    check_frames(2, 32, 80, t_end, "R4");

    // configuration changes during a word are ignored
    cfg_slow_rate = 1'b0;
    src_q.push_back(31'h0F0F_3C3C);
    step(3);
    tx_enable = 1'b1;
    step(60);
    cfg_short_word = 1'b1; cfg_even_parity = 1'b1; cfg_slow_rate = 1'b1;
    wait_empty(t_end);
    step(1);
    tx_enable = 1'b0;
    cfg_short_word = 1'b0; cfg_even_parity = 1'b0; cfg_slow_rate = 1'b0;
    check_frames(1, 32, 10, t_end, "R10");

    // abort mid-word, then resume with the next queued word
    mon_on = 1'b0;
    src_q.push_back(31'h7777_7777);
    src_q.push_back(31'h0246_8ACE);
    step(3);
    tx_enable = 1'b1;
    repeat (100) @(negedge clk);
    step(1);
    tx_enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!line_pos && !line_neg && !bit_clk && !loop_data, "R7", "outputs after abort",
          {line_pos, line_neg, bit_clk, loop_data}, 0);
    check(!word_ready && word_valid, "R7", "second word held after abort", word_ready, 0);
    check(!tx_empty, "R8", "empty while word waits after abort", tx_empty, 0);
    step(4);
    @(negedge clk);
    check(!line_pos && !line_neg && !bit_clk, "R7", "stays quiet after abort",
          {line_pos, line_neg, bit_clk}, 0);
    start_q.delete();
    mon_on = 1'b1;
    run_burst(t_end);
    check_frames(1, 32, 10, t_end, "R7");

    check(exp_q.size() == 0, "R6", "accepted words never sent", exp_q.size(), 0);
    check(tx_empty == 1'b1, "R8", "empty at end", tx_empty, 1);
    finish_run();
  end
endmodule